// File: doc/BRIEF.md
# Next Program Counter Unit

This combinational block chooses the address of the next instruction for a processor whose instructions are all 32 bits wide and start on word boundaries. It takes the current program counter, the fetched instruction word and an equality flag from an external register comparator. It returns the next program counter, together with a return address and a write strobe for the link register.

Four opcodes change the flow of control: jump, jump-and-link, branch-on-equal and branch-on-not-equal. The two branches are position-independent. Their signed 16-bit word offset is scaled to bytes and added to the address of the following instruction. The two jumps are pseudo-direct. They keep the top four bits of the following instruction's address and take the 26-bit word index from the instruction, so a jump reaches only targets in the same sixteenth of the address space. Every other opcode advances by one word.

Top module: `npc_unit`

## Requirements
- R1: When the opcode (instruction bits [31:26]) is anything other than 2, 3, 4 or 5, the next PC is PC+4, with modulo 2^32 wrap. The other instruction bits have no effect on it.
- R2: The link address output is always PC+4. The link write strobe is 1 only for opcode 3 and is 0 for every other opcode.
- R3: For opcode 4 (branch-on-equal) with the equality input at 1, the next PC is PC+4 plus the sign-extended instruction bits [15:0] multiplied by 4.
- R4: For opcode 5 (branch-on-not-equal) with the equality input at 0, the next PC is PC+4 plus the sign-extended instruction bits [15:0] multiplied by 4.
- R5: An untaken branch gives PC+4. That is opcode 4 with the equality input at 0, or opcode 5 with the equality input at 1.
- R6: For opcode 2 (jump), the next PC is bits [31:28] of PC+4, then instruction bits [25:0], then two zero bits.
- R7: Opcode 3 (jump-and-link) computes the same target as R6. In the same cycle it gives the link address PC+4 with the strobe set, even when PC+4 has moved into the next region.
- R8: Branch offsets cover the full signed range: 0x8000 means -32768 words and 0x7FFF means +32767 words. An offset of 0xFFFF loops back to the branch itself.
- R9: When the current PC is word-aligned, bits [1:0] of the next PC are 0 for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Current instruction word |
| regs_eq_i | input | 1 | 1 when the two compared registers are equal |
| next_pc_o | output | 32 | Address of the next instruction to fetch |
| link_addr_o | output | 32 | Return address (PC+4) |
| link_we_o | output | 1 | Link register write strobe |

## Verification
Jump-and-link forms a redirect target and a return address in the same evaluation. Both values come from the one PC+4 sum, so the same evaluation also decides which region the jump lands in. The bench sets the PC to the last word of a region and issues jump-and-link. It then checks the target region, the link address and the strobe together. A separate case checks that a plain jump leaves the strobe low.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'd5;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/npc_seq_add.sv
module npc_seq_add #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] sum_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  assign sum_o = pc_i + STEP_V;
endmodule

// File: rtl/npc_branch.sv
module npc_branch #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMM_W   = 16,
  parameter int unsigned ALIGN_W = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W - ALIGN_W;

  logic [XLEN-1:0] offset;

  // sign extension is pure wiring: the sign bit is copied upward
  generate
    if (ALIGN_W == 0) begin : g_noscale
      assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_scale
      assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    end
  endgenerate

  assign target_o = base_i + offset;
endmodule

// File: rtl/npc_jump.sv
module npc_jump #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned REGION_W = 4,
  parameter int unsigned ALIGN_W  = 2
) (
  input  logic [XLEN-1:0]                  base_i,
  input  logic [XLEN-REGION_W-ALIGN_W-1:0] idx_i,
  output logic [XLEN-1:0]                  target_o
);
  localparam int unsigned REG_LSB = XLEN - REGION_W;

  generate
    if (ALIGN_W == 0) begin : g_noscale
      assign target_o = {base_i[XLEN-1:REG_LSB], idx_i};
    end else begin : g_scale
      assign target_o = {base_i[XLEN-1:REG_LSB], idx_i, {ALIGN_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic             regs_eq_i,
  output npc_sel_e         sel_o,
  output logic             link_we_o
);
  always_comb begin
    sel_o     = SEL_SEQ;
    link_we_o = 1'b0;
    unique case (opc_i)
      OPC_JMP: sel_o = SEL_JMP;
      OPC_JAL: begin
        sel_o     = SEL_JMP;
        link_we_o = 1'b1;
      end
      OPC_BEQ: sel_o = regs_eq_i  ? SEL_BR : SEL_SEQ;
      OPC_BNE: sel_o = !regs_eq_i ? SEL_BR : SEL_SEQ;
      default: sel_o = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned REGION_W = 4,
  parameter int unsigned ALIGN_W  = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            regs_eq_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_addr_o,
  output logic            link_we_o
);
  localparam int unsigned IDX_W   = XLEN - REGION_W - ALIGN_W;
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned STEP    = 1 << ALIGN_W;

  logic [XLEN-1:0] pc_plus;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  npc_sel_e        sel;

  npc_seq_add #(.XLEN(XLEN), .STEP(STEP)) i_seq (
    .pc_i  (pc_i),
    .sum_o (pc_plus)
  );

  npc_branch #(.XLEN(XLEN), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)) i_br (
    .base_i   (pc_plus),
    .imm_i    (instr_i[IMM_W-1:0]),
    .target_o (br_target)
  );

  npc_jump #(.XLEN(XLEN), .REGION_W(REGION_W), .ALIGN_W(ALIGN_W)) i_jmp (
    .base_i   (pc_plus),
    .idx_i    (instr_i[IDX_W-1:0]),
    .target_o (jmp_target)
  );

  npc_decode i_dec (
    .opc_i     (instr_i[XLEN-1:OPC_LSB]),
    .regs_eq_i (regs_eq_i),
    .sel_o     (sel),
    .link_we_o (link_we_o)
  );

  always_comb begin
    unique case (sel)
      SEL_BR:  next_pc_o = br_target;
      SEL_JMP: next_pc_o = jmp_target;
      default: next_pc_o = pc_plus;
    endcase
  end

  assign link_addr_o = pc_plus;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned REGION_W = 4,
  parameter int unsigned ALIGN_W  = 2
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            regs_eq_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] link_addr_o,
  input logic            link_we_o
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned REG_LSB = XLEN - REGION_W;
  localparam int unsigned IDX_W   = XLEN - REGION_W - ALIGN_W;

  logic [OPC_W-1:0] opc;
  assign opc = instr_i[XLEN-1:OPC_LSB];

  always_comb begin
    // R9
    if (pc_i[ALIGN_W-1:0] == '0)
      next_pc_aligned_chk: assert (next_pc_o[ALIGN_W-1:0] == '0)
        else $error("next pc misaligned");
    // R1
    if (opc != OPC_JMP && opc != OPC_JAL && opc != OPC_BEQ && opc != OPC_BNE)
      seq_advance_chk: assert (next_pc_o == link_addr_o && !link_we_o)
        else $error("sequential advance wrong");
    // R5
    if ((opc == OPC_BEQ && !regs_eq_i) || (opc == OPC_BNE && regs_eq_i))
      untaken_branch_chk: assert (next_pc_o == link_addr_o)
        else $error("untaken branch redirected");
    // R2
    if (link_we_o)
      link_strobe_opc_chk: assert (opc == OPC_JAL)
        else $error("link strobe on wrong opcode");
    // R6
    if (opc == OPC_JMP)
      jump_index_chk: assert (next_pc_o[XLEN-1-REGION_W:ALIGN_W] == instr_i[IDX_W-1:0] && !link_we_o)
        else $error("jump index wrong");
    // R7
    if (opc == OPC_JAL)
      jal_region_chk: assert (link_we_o && next_pc_o[XLEN-1:REG_LSB] == link_addr_o[XLEN-1:REG_LSB])
        else $error("jal region or strobe wrong");
  end
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REGION_W(REGION_W), .ALIGN_W(ALIGN_W)) i_chk (
  .pc_i        (pc_i),
  .instr_i     (instr_i),
  .regs_eq_i   (regs_eq_i),
  .next_pc_o   (next_pc_o),
  .link_addr_o (link_addr_o),
  .link_we_o   (link_we_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic        regs_eq_i = 1'b0;
  logic [31:0] next_pc_o;
  logic [31:0] link_addr_o;
  logic        link_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  npc_unit i_npc_unit (
    .pc_i        (pc_i),
    .instr_i     (instr_i),
    .regs_eq_i   (regs_eq_i),
    .next_pc_o   (next_pc_o),
    .link_addr_o (link_addr_o),
    .link_we_o   (link_we_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h exp %08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [31:0] ins, input logic eq);
    @(posedge clk);
    pc_i      = pc;
    instr_i   = ins;
    regs_eq_i = eq;
    @(negedge clk);
  endtask

  function automatic logic [31:0] enc(input int opc, input logic [25:0] rest);
    return {6'(opc), rest};
  endfunction

  function automatic logic [31:0] br_exp(input logic [31:0] pc, input logic [15:0] imm);
    int signed off;
    off = int'($signed(imm));
    return pc + 32'd4 + 32'(off * 4);
  endfunction

  task automatic t_idle;
    apply(32'h0, 32'h0, 1'b0);
    chk("R1 idle next", next_pc_o, 32'h4);
    chk("R2 idle link", link_addr_o, 32'h4);
    chk("R2 idle strobe", 32'(link_we_o), 32'h0);
  endtask

  task automatic t_seq;
    apply(32'h0000_1000, 32'h0123_4567, 1'b1);
    chk("R1 seq op0", next_pc_o, 32'h0000_1004);
    apply(32'h1800_0000, enc(6, 26'h3FF_FFFF), 1'b0);
    chk("R1 seq op6", next_pc_o, 32'h1800_0004);
    chk("R2 op6 strobe", 32'(link_we_o), 32'h0);
    apply(32'hFFFF_FFFC, enc(63, 26'h155_5555), 1'b1);
    chk("R1 wrap", next_pc_o, 32'h0);
    chk("R9 wrap align", 32'(next_pc_o[1:0]), 32'h0);
  endtask

  task automatic t_beq;
    apply(32'h0000_0400, enc(4, {10'h2A5, 16'h0010}), 1'b1);
    chk("R3 beq taken", next_pc_o, br_exp(32'h400, 16'h0010));
    apply(32'h0000_0400, enc(4, {10'h2A5, 16'h0010}), 1'b0);
    chk("R5 beq untaken", next_pc_o, 32'h0000_0404);
    chk("R2 beq strobe", 32'(link_we_o), 32'h0);
  endtask

  task automatic t_bne;
    apply(32'h0000_0400, enc(5, {10'h15A, 16'hFFFF}), 1'b0);
    chk("R4 bne taken self", next_pc_o, 32'h0000_0400);
    chk("R8 minus one", next_pc_o, br_exp(32'h400, 16'hFFFF));
    apply(32'h0000_0400, enc(5, {10'h15A, 16'hFFFF}), 1'b1);
    chk("R5 bne untaken", next_pc_o, 32'h0000_0404);
  endtask

  task automatic t_range;
    apply(32'h0002_0000, enc(4, {10'h0, 16'h8000}), 1'b1);
    chk("R8 min offset", next_pc_o, 32'h0000_0004);
    apply(32'h0000_0000, enc(5, {10'h3FF, 16'h7FFF}), 1'b0);
    chk("R8 max offset", next_pc_o, 32'h0002_0000);
    apply(32'h7FFF_FFF0, enc(4, {10'h0, 16'h0004}), 1'b1);
    chk("R3 cross region", next_pc_o, 32'h8000_0004);
  endtask

  task automatic t_jmp;
    apply(32'h3000_0010, enc(2, 26'h3FF_FFFF), 1'b1);
    chk("R6 jump max idx", next_pc_o, 32'h3FFF_FFFC);
    chk("R6 jump no strobe", 32'(link_we_o), 32'h0);
    apply(32'hA123_4568, enc(2, 26'h000_0000), 1'b0);
    chk("R6 jump zero idx", next_pc_o, 32'hA000_0000);
  endtask

  task automatic t_jal;
    apply(32'h0FFF_FFFC, enc(3, 26'h000_0040), 1'b0);
    chk("R7 jal target", next_pc_o, 32'h1000_0100);
    chk("R7 jal link", link_addr_o, 32'h1000_0000);
    chk("R7 jal strobe", 32'(link_we_o), 32'h1);
    apply(32'h5000_0100, enc(3, 26'h123_4567), 1'b1);
    chk("R7 jal target2", next_pc_o, 32'h548D_159C);
    chk("R2 jal link2", link_addr_o, 32'h5000_0104);
    chk("R9 jal align", 32'(next_pc_o[1:0]), 32'h0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle;
    t_seq;
    t_beq;
    t_bne;
    t_range;
    t_jmp;
    t_jal;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule